// File: doc/BRIEF.md
# Programmable Attribute Memory Router

This block sits in the memory-request path of a host bridge. For every request whose address falls in the legacy window from 0xC0000 to 0xFFFFF, it decides whether the request is served by main DRAM or sent down the I/O link. The window is cut into 13 segments. The twelve lower segments cover 16 KB each, from 0xC0000 up to 0xEFFFF. The top segment covers 64 KB, from 0xF0000 to 0xFFFFF. Each segment has its own read-enable and write-enable.

Firmware programs the attributes through a simple segment-indexed write port and can read them back at any time. A typical use is to copy boot code into DRAM: it turns on write-enable, copies, then turns on read-enable. Addresses outside the window are marked as not belonging to the block.

Non-snooped requests from the I/O side always go to DRAM. An implicit write-back that would land on the I/O link would hang the system. Such a cycle is therefore dropped, and a sticky error flag is raised.

Top module: `pam_router`

## Requirements
- R1: After reset, all 13 segment attributes are 0 and read back as 0, `hang_err` is 0, and `rsp_valid` is 0. A read of 0xF0000 after reset is routed to the link.
- R2: An address is in the window when bits above 19 are zero and bits 19:18 are `11`. Segment indices are assigned as follows:
  - 0xC0000 + k·0x4000 maps to index k, for k = 0..11, each segment 16 KB long.
  - 0xF0000–0xFFFFF maps to index 12.
  - An out-of-window request responds with `rsp_foreign`=1 and both targets 0.
- R3: Attribute encoding is bit 0 = read-enable and bit 1 = write-enable.
  - A write with `cfg_we`=1 stores `cfg_attr` into segment `cfg_seg`.
  - `rb_attr` returns the stored value of `rb_seg` combinationally.
  - Indices 13–15 are ignored on write and read back as 0.
- R4: An in-window read (`req_write`=0, `req_iwb`=0) goes to DRAM when the segment's read-enable is 1, else to the link.
- R5: An in-window write goes to DRAM when the segment's write-enable is 1, else to the link.
- R6: An in-window request with `req_from_io`=1 and `req_snoop`=0 goes to DRAM whatever the attributes.
- R7: An implicit write-back (`req_iwb`=1) is routed as a write.
  - If it resolves to the link, the response has both targets 0 and `rsp_foreign`=0.
  - In that case `hang_err` goes to 1 and stays 1 until reset.
- R8: Response timing:
  - `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1.
  - When `rsp_valid` is 0, `rsp_dram`, `rsp_link` and `rsp_foreign` are all 0.
  - At most one of those three is 1.
- R9: `rsp_addr` equals the request address unchanged, so no segment is remapped.
- R10: A configuration write in the same cycle as a request does not affect that request. The request uses the attribute value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_from_io | input | 1 | 1 = request originates on the I/O side, 0 = CPU |
| req_snoop | input | 1 | 1 = snooped request |
| req_iwb | input | 1 | Request is an implicit write-back |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_seg | input | 4 | Segment index to write |
| cfg_attr | input | 2 | Attribute value, bit 0 read-enable, bit 1 write-enable |
| rb_seg | input | 4 | Segment index to read back |
| rb_attr | output | 2 | Stored attribute of `rb_seg` |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_dram | output | 1 | Target is DRAM |
| rsp_link | output | 1 | Target is the downstream link |
| rsp_foreign | output | 1 | Address outside the window |
| rsp_addr | output | 32 | Address forwarded unchanged |
| hang_err | output | 1 | Sticky fatal error: write-back dropped |

## Verification
Each kind of wrong internal state shows up at the ports within a short, fixed time:
- A corrupted attribute bit is visible at once on `rb_attr`.
- A corrupted attribute bit also flips the target one cycle after the first request that uses it.
- A segment-decode slip moves the DRAM/link boundary off the 16 KB edges. Probing the first and last byte of every segment exposes it.
- A lost or spuriously set error bit is visible on `hang_err` from the cycle after the write-back. It stays visible because the bit is sticky.

// File: rtl/pam_pkg.sv
package pam_pkg;

  localparam int SEG_N    = 13;
  localparam int SEG_W    = 4;
  localparam int ATTR_W   = 2;
  localparam int SMALL_LG = 14;
  localparam int WIN_LG   = 20;

  localparam int ATTR_RD_BIT = 0;
  localparam int ATTR_WR_BIT = 1;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DRAM = 2'd1,
    TGT_LINK = 2'd2
  } tgt_e;

  // offset is addr[19:0] already known to lie in 0xC0000..0xFFFFF
  function automatic logic [SEG_W-1:0] seg_index(input logic [WIN_LG-1:0] off);
    logic [WIN_LG-SMALL_LG-1:0] blk;
    if (off[WIN_LG-1:WIN_LG-4] == 4'hF) begin
      return SEG_W'(SEG_N - 1);
    end
    blk = off[WIN_LG-1:SMALL_LG] - 6'h30;
    return blk[SEG_W-1:0];
  endfunction

  function automatic tgt_e route(input logic is_wr, input logic [ATTR_W-1:0] attr,
                                 input logic from_io, input logic snoop);
    logic en;
    if (from_io && !snoop) begin
      return TGT_DRAM;
    end
    en = is_wr ? attr[ATTR_WR_BIT] : attr[ATTR_RD_BIT];
    return en ? TGT_DRAM : TGT_LINK;
  endfunction

endpackage

// File: rtl/pam_seg_decode.sv
module pam_seg_decode
  import pam_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SEG_W-1:0]  idx
);

  logic upper_zero;

  generate
    if (ADDR_W > WIN_LG) begin : g_upper
      assign upper_zero = ~|addr[ADDR_W-1:WIN_LG];
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign hit = upper_zero && (addr[WIN_LG-1:WIN_LG-2] == 2'b11);
  assign idx = hit ? seg_index(addr[WIN_LG-1:0]) : '0;

  always_comb begin
    if (hit) begin
      assert_idx_range_R2: assert (int'(idx) < SEG_N);
    end
  end

endmodule

// File: rtl/pam_attr_file.sv
module pam_attr_file
  import pam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic [ATTR_W-1:0] wr_val,
  input  logic [SEG_W-1:0]  rb_seg,
  output logic [ATTR_W-1:0] rb_val,
  input  logic [SEG_W-1:0]  lk_seg,
  output logic [ATTR_W-1:0] lk_val
);

  logic [ATTR_W-1:0] attr_q [SEG_N];
  logic [SEG_N*ATTR_W-1:0] attr_flat;
  logic wr_bad_index;

  assign wr_bad_index = wr_en && (int'(wr_seg) >= SEG_N);

  generate
    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          attr_q[g] <= '0;
        end else if (wr_en && (wr_seg == SEG_W'(g))) begin
          attr_q[g] <= wr_val;
        end
      end
      assign attr_flat[g*ATTR_W +: ATTR_W] = attr_q[g];
    end
  endgenerate

  always_comb begin
    rb_val = '0;
    lk_val = '0;
    for (int i = 0; i < SEG_N; i++) begin
      if (rb_seg == SEG_W'(i)) rb_val = attr_q[i];
      if (lk_seg == SEG_W'(i)) lk_val = attr_q[i];
    end
  end

  assert_bad_index_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad_index |=> $stable(attr_flat));

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bad_index) |=> (lk_seg != $past(wr_seg)) || (lk_val == $past(wr_val)));

endmodule

// File: rtl/pam_route_stage.sv
module pam_route_stage
  import pam_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_from_io,
  input  logic              req_snoop,
  input  logic              req_iwb,
  input  logic              seg_hit,
  input  logic [ATTR_W-1:0] seg_attr,
  output logic              rsp_valid,
  output logic              rsp_dram,
  output logic              rsp_link,
  output logic              rsp_foreign,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              hang_err
);

  tgt_e tgt_c;
  logic eff_write;
  logic iwb_hang;
  logic io_bypass;

  assign eff_write = req_write | req_iwb;
  assign tgt_c     = seg_hit ? route(eff_write, seg_attr, req_from_io, req_snoop) : TGT_NONE;
  assign iwb_hang  = req_valid && seg_hit && req_iwb && (tgt_c == TGT_LINK);
  assign io_bypass = req_valid && seg_hit && req_from_io && !req_snoop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_dram    <= 1'b0;
      rsp_link    <= 1'b0;
      rsp_foreign <= 1'b0;
      rsp_addr    <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_dram    <= req_valid && (tgt_c == TGT_DRAM);
      rsp_link    <= req_valid && (tgt_c == TGT_LINK) && !iwb_hang;
      rsp_foreign <= req_valid && !seg_hit;
      if (req_valid) rsp_addr <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hang_err <= 1'b0;
    end else if (iwb_hang) begin
      hang_err <= 1'b1;
    end
  end

  assert_resp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_dram || rsp_link || rsp_foreign));
  assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_dram, rsp_link, rsp_foreign}));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hang_err |=> hang_err);
  assert_hang_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iwb_hang |=> (rsp_valid && !rsp_dram && !rsp_link && !rsp_foreign && hang_err));
  assert_io_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_bypass |=> rsp_dram);
  assert_addr_unchanged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_addr == $past(req_addr)));

endmodule

// File: rtl/pam_router.sv
module pam_router
  import pam_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_from_io,
  input  logic              req_snoop,
  input  logic              req_iwb,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_seg,
  input  logic [ATTR_W-1:0] cfg_attr,
  input  logic [SEG_W-1:0]  rb_seg,
  output logic [ATTR_W-1:0] rb_attr,
  output logic              rsp_valid,
  output logic              rsp_dram,
  output logic              rsp_link,
  output logic              rsp_foreign,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              hang_err
);

  logic              seg_hit;
  logic [SEG_W-1:0]  seg_idx;
  logic [ATTR_W-1:0] seg_attr;

  pam_seg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (req_addr),
    .hit  (seg_hit),
    .idx  (seg_idx)
  );

  pam_attr_file u_attr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_seg (cfg_seg),
    .wr_val (cfg_attr),
    .rb_seg (rb_seg),
    .rb_val (rb_attr),
    .lk_seg (seg_idx),
    .lk_val (seg_attr)
  );

  pam_route_stage #(.ADDR_W(ADDR_W)) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_from_io (req_from_io),
    .req_snoop   (req_snoop),
    .req_iwb     (req_iwb),
    .seg_hit     (seg_hit),
    .seg_attr    (seg_attr),
    .rsp_valid   (rsp_valid),
    .rsp_dram    (rsp_dram),
    .rsp_link    (rsp_link),
    .rsp_foreign (rsp_foreign),
    .rsp_addr    (rsp_addr),
    .hang_err    (hang_err)
  );

endmodule

// File: tb/tb_pam_router.sv
`timescale 1ns/1ps
module tb_pam_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_from_io = 1'b0;
  logic        req_snoop = 1'b0;
  logic        req_iwb = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_seg = '0;
  logic [1:0]  cfg_attr = '0;
  logic [3:0]  rb_seg = '0;
  logic [1:0]  rb_attr;
  logic        rsp_valid, rsp_dram, rsp_link, rsp_foreign, hang_err;
  logic [31:0] rsp_addr;

  int n_tests = 0;
  int n_fail  = 0;
  logic [1:0] model [13];

  always #10 clk = ~clk;

  pam_router dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_from_io(req_from_io), .req_snoop(req_snoop),
    .req_iwb(req_iwb), .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_attr(cfg_attr),
    .rb_seg(rb_seg), .rb_attr(rb_attr), .rsp_valid(rsp_valid), .rsp_dram(rsp_dram),
    .rsp_link(rsp_link), .rsp_foreign(rsp_foreign), .rsp_addr(rsp_addr),
    .hang_err(hang_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] s, input logic [1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = s; cfg_attr = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s < 13) model[s] = v;
  endtask

  task automatic send(input logic [31:0] a, input logic w, input logic io,
                      input logic sn, input logic iwb);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    req_from_io = io; req_snoop = sn; req_iwb = iwb;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // expected routing from the requirements: {dram, link, foreign}
  function automatic logic [2:0] expect_route(input logic [31:0] a, input logic w,
                                              input logic io, input logic sn,
                                              input logic iwb);
    int s;
    logic en;
    if (a < 32'hC0000 || a > 32'hFFFFF) return 3'b001;
    s = (a >= 32'hF0000) ? 12 : int'((a - 32'hC0000) / 32'h4000);
    if (io && !sn) return 3'b100;
    en = (w || iwb) ? model[s][1] : model[s][0];
    if (en) return 3'b100;
    if (iwb) return 3'b000;
    return 3'b010;
  endfunction

  task automatic send_check(input string req, input logic [31:0] a, input logic w,
                            input logic io, input logic sn, input logic iwb);
    logic [2:0] e;
    e = expect_route(a, w, io, sn, iwb);
    send(a, w, io, sn, iwb);
    check(req, "valid", {31'd0, rsp_valid}, 32'd1);
    check(req, "route", {29'd0, rsp_dram, rsp_link, rsp_foreign}, {29'd0, e});
    check("R9", "addr", rsp_addr, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 13; i++) model[i] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1", "hang_err", {31'd0, hang_err}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      rb_seg = 4'(i); #1;
      check("R1", "rb_attr", {30'd0, rb_attr}, 32'd0);
    end
    send_check("R1", 32'hF0000, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R1", "link", {31'd0, rsp_link}, 32'd1);

    // R8: idle cycle after a response
    @(negedge clk);
    check("R8", "idle valid", {31'd0, rsp_valid}, 32'd0);
    check("R8", "idle targets", {29'd0, rsp_dram, rsp_link, rsp_foreign}, 32'd0);

    // R2: out-of-window addresses
    send_check("R2", 32'h000BFFFF, 1'b0, 1'b0, 1'b1, 1'b0);
    send_check("R2", 32'h00100000, 1'b1, 1'b0, 1'b1, 1'b0);
    send_check("R2", 32'h00000000, 1'b0, 1'b1, 1'b0, 1'b0);
    send_check("R2", 32'h800F0000, 1'b1, 1'b1, 1'b1, 1'b0);

    // R3/R4/R5/R6/R2: sweep segments x attributes x kinds
    for (int s = 0; s < 13; s++) begin
      for (int v = 0; v < 4; v++) begin
        logic [31:0] base, last;
        cfg_write(4'(s), 2'(v));
        rb_seg = 4'(s); #1;
        check("R3", "readback", {30'd0, rb_attr}, 32'(v));
        base = (s < 12) ? 32'hC0000 + 32'(s) * 32'h4000 : 32'hF0000;
        last = base + ((s < 12) ? 32'h3FFF : 32'hFFFF);
        for (int k = 0; k < 8; k++) begin
          logic w, io, sn;
          w = k[0]; io = k[1]; sn = k[2];
          send_check((io && !sn) ? "R6" : (w ? "R5" : "R4"), base, w, io, sn, 1'b0);
          send_check("R2", last, w, io, sn, 1'b0);
        end
      end
    end

    // R3: out-of-range indices ignored
    for (int s = 13; s < 16; s++) begin
      cfg_write(4'(s), 2'b00);
      rb_seg = 4'(s); #1;
      check("R3", "bad index readback", {30'd0, rb_attr}, 32'd0);
    end
    for (int s = 0; s < 13; s++) begin
      rb_seg = 4'(s); #1;
      check("R3", "untouched", {30'd0, rb_attr}, 32'd3);
    end

    // R10: same-cycle config write does not affect the request
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = 4'd0; cfg_attr = 2'b00;
    req_valid = 1'b1; req_addr = 32'hC0010; req_write = 1'b0;
    req_from_io = 1'b0; req_snoop = 1'b1; req_iwb = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    model[0] = 2'b00;
    check("R10", "old attr used", {29'd0, rsp_dram, rsp_link, rsp_foreign}, 32'b100);
    send_check("R10", 32'hC0010, 1'b0, 1'b0, 1'b1, 1'b0);

    // R7: implicit write-back
    cfg_write(4'd1, 2'b11);
    send_check("R7", 32'hC4000, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R7", "no err", {31'd0, hang_err}, 32'd0);
    cfg_write(4'd1, 2'b01);
    send_check("R7", 32'hC4000, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R7", "err set", {31'd0, hang_err}, 32'd1);
    send_check("R7", 32'hC4000, 1'b0, 1'b1, 1'b0, 1'b1);
    send_check("R7", 32'hC4000, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R7", "err sticky", {31'd0, hang_err}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "err cleared", {31'd0, hang_err}, 32'd0);
    rb_seg = 4'd1; #1;
    check("R1", "attr cleared", {30'd0, rb_attr}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule